// File: doc/BRIEF.md
# Dual-Channel Multiplexed Sample Output Stage

This block is the digital back end of a two-channel sampling converter. On every rising clock edge it accepts one I sample and one Q sample taken at the same instant. Each channel travels through its own fixed-latency delay line. The Q line ends in a stage clocked on the falling edge, so Q arrives half a clock after I. One shared bus carries one channel at a time, chosen by a select input. When select is tied to the clock itself, I occupies the bus in the high phase and Q in the low phase, so both channels share the bus in every cycle.

An active-low output enable floats the bus. The block does not use internal tri-state buffers. It exposes a drive-enable signal and a separate data vector, and the pad ring builds the tri-state buffer from them. While the bus is floated, sampling and both delay lines keep running, so re-enabling the bus shows the current data at once.

Data enters as a stream qualified by `smp_vld`. A converter cannot stall, so the block has no ready signal and applies no back-pressure. Every beat marked by `bus_vld` must be taken by the consumer in the phase in which it appears. An invalid beat (a bubble) travels through the pipeline like a sample and comes out as an invalid bus slot.

Top module: `dualch_outmux`

## Requirements
- R1: Both 12-bit samples `smp_i` and `smp_q` are captured on the same rising edge, and only when `smp_vld` is 1. An edge with `smp_vld` 0 produces an invalid slot in each channel, and that slot reaches the bus at the same latency as a sample would.
- R2: A sample of I captured on rising edge e appears on the I path right after rising edge e+7, and stays there until rising edge e+8.
- R3: A sample of Q captured on rising edge e appears on the Q path right after the falling edge that follows rising edge e+7 (latency 7.5 cycles), and stays there until the next falling edge.
- R4: With `sel` = 1 the bus carries the I path. With `sel` = 0 it carries the Q path.
- R5: With `sel` driven by the clock, the bus carries I during the high phase and Q during the low phase.
- R6: With `oe_n` = 1, `bus_oe` is 0 and `bus_vld` is 0, while `bus_dat` and both delay lines keep advancing. When `oe_n` returns to 0, `bus_oe` is 1 and the current valid data is flagged in the same phase. No sample is lost or reordered.
- R7: A synchronous active-high `rst` clears every stage valid bit. After reset, and whenever the selected path holds an invalid slot, `bus_dat` is 0 and `bus_vld` is 0. This holds until the first sample has passed the full latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; rising edge samples, falling edge launches Q |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Input beat qualifier for both channels |
| smp_i | input | 12 | I-channel sample |
| smp_q | input | 12 | Q-channel sample |
| sel | input | 1 | 1 = I on bus, 0 = Q on bus; may be tied to clk |
| oe_n | input | 1 | Active-low bus drive enable |
| bus_dat | output | 12 | Shared bus data (0 when the selected slot is invalid) |
| bus_oe | output | 1 | Drive enable for the pad tri-state buffer |
| bus_vld | output | 1 | Bus carries a valid sample and is driven |

## Verification
The floating of the bus and the interleave of the two channels can fall in the same cycle. With `sel` tied to the clock, `oe_n` pulses for two cycles at a time, so both the I half and the Q half of a cycle are sometimes floated. Three things are judged in every half cycle: the flag is dropped while `oe_n` is high, the data vector still shows the ramp value that the latency arithmetic predicts, and the next enabled half shows the next ramp value with none skipped. Input bubbles land in both channels at once and must come out as invalid slots at 7 and 7.5 cycles.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  parameter int unsigned SMP_W_DEF = 12;
  parameter int unsigned LAT_DEF   = 7;

  typedef enum logic {
    CH_Q = 1'b0,
    CH_I = 1'b1
  } ch_sel_e;
endpackage

// File: rtl/smp_pipe.sv
module smp_pipe #(
  parameter int unsigned W     = 12,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [W-1:0] in_dat,
  output logic         out_vld,
  output logic [W-1:0] out_dat
);
  logic [W-1:0] dq [DEPTH];
  logic [DEPTH-1:0] vq;

  always_ff @(posedge clk) begin
    if (rst) vq[0] <= 1'b0;
    else     vq[0] <= in_vld;
    dq[0] <= in_dat;
  end

  for (genvar j = 1; j < DEPTH; j++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) vq[j] <= 1'b0;
      else     vq[j] <= vq[j-1];
      dq[j] <= dq[j-1];
    end
  end

  assign out_vld = vq[DEPTH-1];
  assign out_dat = dq[DEPTH-1];

  // R1: an edge without a beat leaves an empty capture slot
  a_r1_bubble_captured: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !vq[0]);
endmodule

// File: rtl/halfcyc_stage.sv
module halfcyc_stage #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         din_vld,
  input  logic [W-1:0] din,
  output logic         dout_vld,
  output logic [W-1:0] dout
);
  always_ff @(negedge clk) begin
    if (rst) dout_vld <= 1'b0;
    else     dout_vld <= din_vld;
    dout <= din;
  end

  // R3: at each rising edge the retimed output equals what its input held
  // for the previous half cycle, i.e. it trails by exactly half a clock
  a_r3_half_cycle_retime: assert property (@(posedge clk) disable iff (rst)
    (dout_vld == din_vld) && (!din_vld || dout == din));
endmodule

// File: rtl/bus_sel.sv
module bus_sel
  import dcm_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel,
  input  logic         oe_n,
  input  logic         i_vld,
  input  logic [W-1:0] i_dat,
  input  logic         q_vld,
  input  logic [W-1:0] q_dat,
  output logic [W-1:0] bus_dat,
  output logic         bus_oe,
  output logic         bus_vld
);
  ch_sel_e      ch;
  logic         s_vld;
  logic [W-1:0] s_dat;

  always_comb begin
    ch = ch_sel_e'(sel);
    if (ch == CH_I) begin
      s_vld = i_vld;
      s_dat = i_dat;
    end else begin
      s_vld = q_vld;
      s_dat = q_dat;
    end
    bus_dat = s_vld ? s_dat : '0;
    bus_oe  = !oe_n;
    bus_vld = s_vld && !oe_n;
  end

  // R6: a floated bus never flags data
  a_r6_float_no_flag: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (!bus_oe && !bus_vld));
endmodule

// File: rtl/dualch_outmux.sv
module dualch_outmux
  import dcm_pkg::*;
#(
  parameter int unsigned W   = SMP_W_DEF,
  parameter int unsigned LAT = LAT_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp_vld,
  input  logic [W-1:0] smp_i,
  input  logic [W-1:0] smp_q,
  input  logic         sel,
  input  logic         oe_n,
  output logic [W-1:0] bus_dat,
  output logic         bus_oe,
  output logic         bus_vld
);
  localparam int unsigned DEPTH = LAT + 1;
  localparam int unsigned CW    = $clog2(LAT + 2) + 1;

  logic         i_vld, q_mid_vld, q_vld;
  logic [W-1:0] i_dat, q_mid_dat, q_dat;

  smp_pipe #(.W(W), .DEPTH(DEPTH)) u_ipipe (
    .clk(clk), .rst(rst), .in_vld(smp_vld), .in_dat(smp_i),
    .out_vld(i_vld), .out_dat(i_dat)
  );

  smp_pipe #(.W(W), .DEPTH(DEPTH)) u_qpipe (
    .clk(clk), .rst(rst), .in_vld(smp_vld), .in_dat(smp_q),
    .out_vld(q_mid_vld), .out_dat(q_mid_dat)
  );

  halfcyc_stage #(.W(W)) u_qhalf (
    .clk(clk), .rst(rst), .din_vld(q_mid_vld), .din(q_mid_dat),
    .dout_vld(q_vld), .dout(q_dat)
  );

  bus_sel #(.W(W)) u_sel (
    .clk(clk), .rst(rst), .sel(sel), .oe_n(oe_n),
    .i_vld(i_vld), .i_dat(i_dat), .q_vld(q_vld), .q_dat(q_dat),
    .bus_dat(bus_dat), .bus_oe(bus_oe), .bus_vld(bus_vld)
  );

  // Rising edges since reset, saturating; used only by the fill check
  logic [CW-1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                           since_rst <= '0;
    else if (since_rst <= CW'(LAT))    since_rst <= since_rst + 1'b1;
  end

  // R7: neither path can show a valid slot before the full latency has elapsed
  a_r7_no_valid_before_fill: assert property (@(posedge clk) disable iff (rst)
    (since_rst <= CW'(LAT)) |-> (!i_vld && !q_vld));
endmodule

// File: tb/dualch_outmux_tb.sv
module dualch_outmux_tb;
  localparam int W = 12;
  localparam int N = 600;
  localparam int MASK = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_vld = 1'b0;
  logic [W-1:0] smp_i = '0, smp_q = '0;
  logic oe_n = 1'b0;
  int mode = 0;  // 0 sel high, 1 sel low, 2 sel tied to clk
  logic sel_w;
  logic [W-1:0] bus_dat;
  logic bus_oe, bus_vld;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int app_i [N];
  int app_q [N];
  bit app_v [N];
  bit app_r [N];

  always #10 clk = ~clk;
  assign sel_w = (mode == 2) ? clk : (mode == 0);

  dualch_outmux u_dut (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_i(smp_i), .smp_q(smp_q),
    .sel(sel_w), .oe_n(oe_n), .bus_dat(bus_dat), .bus_oe(bus_oe), .bus_vld(bus_vld)
  );

  // idx = iteration whose applied inputs are expected; isq selects Q
  task automatic check(input int idx, input bit isq, input bit tie);
    bit ev;
    int ed;
    string lbl;
    ev = (idx >= 0) && !app_r[idx > 0 ? idx : 0] && app_v[idx > 0 ? idx : 0];
    ed = ev ? (isq ? app_q[idx] : app_i[idx]) : 0;
    lbl = isq ? "R3" : "R2";
    lbl = {lbl, tie ? " R5" : " R4"};
    if (idx < 0 || app_r[idx > 0 ? idx : 0]) lbl = {lbl, " R7"};
    else if (!ev) lbl = {lbl, " R1"};
    if (oe_n) lbl = {lbl, " R6"};
    n_chk++;
    if (bus_dat !== ed[W-1:0] || bus_vld !== (ev && !oe_n) || bus_oe !== !oe_n) begin
      n_bad++;
      $display("FAIL %s iter %0d: dat=%0d vld=%0b oe=%0b expected dat=%0d vld=%0b oe=%0b",
               lbl, idx, bus_dat, bus_vld, bus_oe, ed, ev && !oe_n, !oe_n);
    end
  endtask

  initial begin
    for (int k = 0; k < N; k++) begin
      @(posedge clk);
      #5;
      // high phase of the cycle following rising edge k
      if (mode == 1) check(k - 9, 1'b1, 1'b0);
      else           check(k - 8, 1'b0, mode == 2);
      // apply the beat sampled at rising edge k+1
      rst     = (k < 3);
      smp_vld = (k % 7 != 3);
      smp_i   = W'((k * 3 + 100) & MASK);
      smp_q   = W'((k * 11 + 2000) & MASK);
      oe_n    = ((k % 9) == 4) || ((k % 9) == 5);
      mode    = (k < 200) ? 0 : (k < 400) ? 1 : 2;
      app_i[k] = int'(smp_i);
      app_q[k] = int'(smp_q);
      app_v[k] = smp_vld;
      app_r[k] = rst;
      #10;
      // low phase, after the falling edge
      if (mode == 0) check(k - 8, 1'b0, 1'b0);
      else           check(k - 8, 1'b1, mode == 2);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule